// File: doc/BRIEF.md
# Two-Stage Key-Protected Watchdog Timer

This block is a watchdog peripheral on a simple synchronous register port. Once enabled it runs two countdowns one after the other. The first stage can raise an interrupt when it runs out, which warns software that the deadline is close. The second stage then drives a reset request output and sets a timeout flag. This flag survives the system reset that the request causes. Software keeps the system alive by reloading both stages before the first one expires.

The preload registers and the reload register are guarded by a two-write key. The word 0x80 and then the word 0x86 are written to the reload register. After that, exactly one write to a guarded register is accepted. An enable/lock register starts and stops the timer. Once its lock bit is set, that register is frozen until the next system reset. A configuration register sets the following:
- the tick rate, taken from a prescaler on the bus clock;
- the stage-1 interrupt type;
- whether the reset output is driven.

Register offsets on `addr`:
- 0x00: stage-1 preload
- 0x04: stage-2 preload
- 0x08: interrupt status
- 0x0C: reload/status
- 0x10: configuration
- 0x14: enable/lock

Reads are combinational on `rdata`.

The timer state machine has four states:
- `ST_IDLE`: the timer is stopped.
- `ST_STAGE1`: first countdown.
- `ST_STAGE2`: second countdown.
- `ST_FIRED`: the reset is being requested.

Its transitions:
- **start**: `ST_IDLE` to `ST_STAGE1` when enable is set.
- **kick**: `ST_STAGE1`/`ST_STAGE2` to `ST_STAGE1` on an accepted reload.
- **warn**: `ST_STAGE1` to `ST_STAGE2` on stage-1 expiry.
- **bite**: `ST_STAGE2` to `ST_FIRED` on stage-2 expiry in watchdog mode.
- **wrap**: `ST_STAGE2` to `ST_STAGE1` on stage-2 expiry in timer mode.
- **stop**: any state to `ST_IDLE` when enable is clear.

The key sequencer has three states:
- `UK_NONE`: no key entered.
- `UK_HALF`: the first key word has been seen.
- `UK_OPEN`: one guarded write is allowed.

Top module: `wdt_top`

## Requirements
- R1: After system reset both preloads read RST_PRELOAD (default 512). Interrupt status, configuration and enable/lock read 0. `irq_o` and `wdt_rst_o` are low.
- R2: Writing 0x80 and then 0x86 to offset 0x0C allows exactly one write to a guarded offset (0x00, 0x04 or 0x0C). A second guarded write without a new key is ignored.
- R3: A guarded write without the full key is ignored. This includes the case where a wrong word was written between 0x80 and 0x86.
- R4: The preloads hold bits 19:0 of the written word. Bits 31:20 are ignored and read back as 0.
- R5: Enable/lock (offset 0x14) has bit 0 = lock, bit 1 = enable and bit 2 = function. While lock is 1, writes to this register are ignored until system reset.
- R6: Writing 0 to enable (while unlocked) stops the countdown. No interrupt and no reset output follow.
- R7: After enable, stage 1 expires on tick number max(P1,1). This sets status bit 0 at 0x08 and `irq_o`. Stage 2 then expires exactly max(P2,1) ticks later and drives `wdt_rst_o`.
- R8: Configuration (offset 0x10) bit 2 = 0 gives one tick per 2^SLOW_SHIFT clocks. Bit 2 = 1 gives one tick per 2^FAST_SHIFT clocks.
- R9: Configuration bits 1:0 = 11 suppress the stage-1 interrupt. Writing 1 to bit 0 of offset 0x08 clears the status bit and `irq_o`.
- R10: Configuration bit 5 = 1 keeps `wdt_rst_o` low on stage-2 expiry, but the timeout flag is still set.
- R11: The timeout flag (bit 9 at 0x0C) is set on stage-2 expiry and survives `rst_n`. It is cleared by a keyed write with bit 9 set, or by `por_n`.
- R12: A keyed write to 0x0C with bit 8 set restarts stage 1 from its preload. Kicks spaced closer than the stage-1 time keep `irq_o` low.
- R13: With function = 1 (timer mode), stage-2 expiry restarts stage 1. The timeout flag and `wdt_rst_o` are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low; also clears the timeout flag |
| rst_n | input | 1 | System reset, active low; leaves the timeout flag alone |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_o | output | 1 | Stage-1 interrupt (level) |
| wdt_rst_o | output | 1 | Reset request on stage-2 expiry |

## Verification
The hardest situation to reach is the exact tick on which stage 2 expires. The tick phase against the enable write is unknown, so the bench bounds the stage-1 interval as a range. It then measures from the interrupt edge, which is tick-aligned, to the reset edge and requires that interval to be exact. A near-exhaustive sweep does this over small preloads, including zero, on the fast tick, with one slow-tick case. A reset request followed by a system reset is what proves that the flag is sticky. Timing the kicks against the minimum stage-1 time is what proves that keepalive works.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STAGE1,
        ST_STAGE2,
        ST_FIRED
    } wdt_state_e;

    typedef enum logic [1:0] {
        UK_NONE,
        UK_HALF,
        UK_OPEN
    } key_state_e;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_PRE1   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE2   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_ISTAT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 5'h14;

    localparam logic [31:0] KEY_FIRST  = 32'h0000_0080;
    localparam logic [31:0] KEY_SECOND = 32'h0000_0086;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    output logic tick
);
    logic [SLOW_SHIFT-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // A tick fires once per wrap of the selected low bits.
    always_comb begin
        tick = fast_sel ? (&div_q[FAST_SHIFT-1:0]) : (&div_q);
    end
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic        guard_wr,
    input  logic [31:0] data,
    output logic        open_o,
    output logic        accept_o
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UK_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UK_NONE: begin
                if (key_wr) begin
                    state_d = (data == KEY_FIRST) ? UK_HALF : UK_NONE;
                end
            end
            UK_HALF: begin
                if (key_wr) begin
                    if (data == KEY_SECOND) begin
                        state_d = UK_OPEN;
                    end else if (data == KEY_FIRST) begin
                        state_d = UK_HALF;
                    end else begin
                        state_d = UK_NONE;
                    end
                end
            end
            UK_OPEN: begin
                if (guard_wr) begin
                    state_d = (key_wr && data == KEY_FIRST) ? UK_HALF : UK_NONE;
                end
            end
            default: state_d = UK_NONE;
        endcase
    end

    always_comb begin
        open_o   = (state_q == UK_OPEN);
        accept_o = guard_wr && (state_q == UK_OPEN);
    end
endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm
    import wdt_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             wd_mode,
    input  logic             kick,
    input  logic [PRE_W-1:0] pre1,
    input  logic [PRE_W-1:0] pre2,
    output wdt_state_e       state_o,
    output logic             warn_o,
    output logic             bite_o
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    wdt_state_e       state_q, state_d;
    logic [PRE_W-1:0] cnt_q, cnt_d;
    logic             last_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        last_tick = tick && (cnt_q <= ONE);
        state_d   = state_q;
        cnt_d     = cnt_q;
        warn_o    = 1'b0;
        bite_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    state_d = ST_STAGE1;
                    cnt_d   = pre1;
                end
            end
            ST_STAGE1: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (kick) begin
                    cnt_d = pre1;
                end else if (last_tick) begin
                    state_d = ST_STAGE2;
                    cnt_d   = pre2;
                    warn_o  = 1'b1;
                end else if (tick) begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_STAGE2: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end else if (kick) begin
                    state_d = ST_STAGE1;
                    cnt_d   = pre1;
                end else if (last_tick) begin
                    bite_o = 1'b1;
                    if (wd_mode) begin
                        state_d = ST_FIRED;
                    end else begin
                        state_d = ST_STAGE1;
                        cnt_d   = pre1;
                    end
                end else if (tick) begin
                    cnt_d = cnt_q - ONE;
                end
            end
            ST_FIRED: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o = state_q;
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int PRE_W       = 20,
    parameter int RST_PRELOAD = 512,
    parameter int SLOW_SHIFT  = 15,
    parameter int FAST_SHIFT  = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(RST_PRELOAD);
    localparam int LOCK_BIT = 0;
    localparam int EN_BIT   = 1;
    localparam int FUNC_BIT = 2;

    logic [PRE_W-1:0] pre1_q, pre2_q;
    logic [7:0]       cfg_q;
    logic [2:0]       lock_q;
    logic             istat_q;
    logic             flag_q;

    logic       key_wr, guard_wr, unlock_open, prot_accept;
    logic       tick, run, wd_mode, kick, warn, bite;
    wdt_state_e fsm_state;

    always_comb begin
        key_wr   = wr_en && (addr == OFS_RELOAD);
        guard_wr = wr_en && (addr == OFS_PRE1 || addr == OFS_PRE2 || addr == OFS_RELOAD);
        run      = lock_q[EN_BIT];
        wd_mode  = !lock_q[FUNC_BIT];
        kick     = prot_accept && (addr == OFS_RELOAD) && wdata[8];
    end

    wdt_prescale #(
        .SLOW_SHIFT(SLOW_SHIFT),
        .FAST_SHIFT(FAST_SHIFT)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_sel(cfg_q[2]),
        .tick    (tick)
    );

    wdt_unlock u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .guard_wr(guard_wr),
        .data    (wdata),
        .open_o  (unlock_open),
        .accept_o(prot_accept)
    );

    wdt_stage_fsm #(
        .PRE_W(PRE_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (run),
        .wd_mode(wd_mode),
        .kick   (kick),
        .pre1   (pre1_q),
        .pre2   (pre2_q),
        .state_o(fsm_state),
        .warn_o (warn),
        .bite_o (bite)
    );

    // Register file cleared by system reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre1_q  <= PRE_INIT;
            pre2_q  <= PRE_INIT;
            cfg_q   <= '0;
            lock_q  <= '0;
            istat_q <= 1'b0;
        end else begin
            if (prot_accept && addr == OFS_PRE1) begin
                pre1_q <= wdata[PRE_W-1:0];
            end
            if (prot_accept && addr == OFS_PRE2) begin
                pre2_q <= wdata[PRE_W-1:0];
            end
            if (wr_en && addr == OFS_CFG) begin
                cfg_q <= wdata[7:0];
            end
            if (wr_en && addr == OFS_LOCK && !lock_q[LOCK_BIT]) begin
                lock_q <= wdata[2:0];
            end
            if (warn && cfg_q[1:0] != 2'b11) begin
                istat_q <= 1'b1;
            end else if (wr_en && addr == OFS_ISTAT && wdata[0]) begin
                istat_q <= 1'b0;
            end
        end
    end

    // Timeout flag lives on the power-on reset only.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (bite && wd_mode) begin
            flag_q <= 1'b1;
        end else if (prot_accept && addr == OFS_RELOAD && wdata[9]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        irq_o     = istat_q;
        wdt_rst_o = (fsm_state == ST_FIRED) && !cfg_q[5];
        rdata     = '0;
        unique case (addr)
            OFS_PRE1:   rdata = 32'(pre1_q);
            OFS_PRE2:   rdata = 32'(pre2_q);
            OFS_ISTAT:  rdata = {31'b0, istat_q};
            OFS_RELOAD: rdata = {22'b0, flag_q, 9'b0};
            OFS_CFG:    rdata = {24'b0, cfg_q};
            OFS_LOCK:   rdata = {29'b0, lock_q};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input wdt_state_e fsm_state,
    input logic       run,
    input logic       unlock_open,
    input logic       prot_accept,
    input logic [2:0] lock_bits,
    input logic       flag
);
    // R2: an accepted guarded write uses up the key
    a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        prot_accept |=> !unlock_open);

    // R5: a set lock freezes the enable/lock register
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_bits[0] |=> $stable(lock_bits));

    // R6: clearing enable returns the timer to idle
    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (fsm_state == ST_IDLE));

    // R7: the fired state is reached only through stage 2
    a_r7_fire_after_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_FIRED) |->
            ($past(fsm_state) == ST_STAGE2 || $past(fsm_state) == ST_FIRED));

    // R11: entering the fired state leaves the timeout flag set
    a_r11_flag_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_state == ST_FIRED) |-> flag);
endmodule

bind wdt_top wdt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsm_state  (fsm_state),
    .run        (run),
    .unlock_open(unlock_open),
    .prot_accept(prot_accept),
    .lock_bits  (lock_q),
    .flag       (flag_q)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW_SH = 6;
    localparam int FAST_SH = 2;
    localparam int P_SLOW = 1 << SLOW_SH;
    localparam int P_FAST = 1 << FAST_SH;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, wdt_rst_o;

    int checks = 0;
    int fails = 0;
    bit mon_en = 0;
    bit saw_irq = 0;
    bit saw_rst = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_top #(
        .PRE_W(20), .RST_PRELOAD(512), .SLOW_SHIFT(SLOW_SH), .FAST_SHIFT(FAST_SH)
    ) dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    always @(negedge clk) begin
        if (mon_en && irq_o) saw_irq = 1;
        if (mon_en && wdt_rst_o) saw_rst = 1;
    end

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic unl();
        wr(5'h0C, 32'h80);
        wr(5'h0C, 32'h86);
    endtask

    task automatic sysreset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq_o && n < 5000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic wait_rst(output int n);
        n = 0;
        while (!wdt_rst_o && n < 5000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic run_case(input int p1, input int p2, input bit fast);
        int per, e1, e2, n1, n2;
        logic [31:0] d;
        per = fast ? P_FAST : P_SLOW;
        e1 = (p1 < 1) ? 1 : p1;
        e2 = (p2 < 1) ? 1 : p2;
        sysreset();
        unl(); wr(5'h00, 32'(p1));
        unl(); wr(5'h04, 32'(p2));
        wr(5'h10, fast ? 32'h4 : 32'h0);
        wr(5'h14, 32'h2);
        wait_irq(n1);
        chk("R7 stage-1 interval", n1 >= (e1 - 1) * per + 1 && n1 <= e1 * per, n1, e1 * per);
        wait_rst(n2);
        chk(fast ? "R7 stage-2 interval fast tick" : "R8 stage-2 interval slow tick",
            n2 == e2 * per, n2, e2 * per);
        rd(5'h0C, d);
        chk("R11 flag set on bite", d[9] == 1'b1, d[9], 1);
    endtask

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;

        // R1 reset values
        rd(5'h00, d); chk("R1 pre1 reset", d == 512, d, 512);
        rd(5'h04, d); chk("R1 pre2 reset", d == 512, d, 512);
        rd(5'h08, d); chk("R1 istat reset", d == 0, d, 0);
        rd(5'h10, d); chk("R1 cfg reset", d == 0, d, 0);
        rd(5'h14, d); chk("R1 lock reset", d == 0, d, 0);
        chk("R1 outputs low", !irq_o && !wdt_rst_o, {irq_o, wdt_rst_o}, 0);

        // R3 no key / broken key
        wr(5'h00, 32'h11);
        rd(5'h00, d); chk("R3 unkeyed write ignored", d == 512, d, 512);
        wr(5'h0C, 32'h80); wr(5'h0C, 32'h55); wr(5'h0C, 32'h86); wr(5'h00, 32'h22);
        rd(5'h00, d); chk("R3 broken key ignored", d == 512, d, 512);

        // R2 one write per key
        unl(); wr(5'h04, 32'h33); wr(5'h04, 32'h44);
        rd(5'h04, d); chk("R2 single write", d == 32'h33, d, 32'h33);
        unl(); wr(5'h04, 32'h55);
        rd(5'h04, d); chk("R2 fresh key", d == 32'h55, d, 32'h55);

        // R4 width
        unl(); wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, d); chk("R4 upper bits ignored", d == 32'h000F_FFFF, d, 32'h000F_FFFF);

        // R7/R8/R11 sweep
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                run_case(a, b, 1'b1);
            end
        end
        run_case(2, 1, 1'b0);

        // R11 flag survives system reset, then clears with a keyed write
        sysreset();
        chk("R11 rst output dropped", !wdt_rst_o, wdt_rst_o, 0);
        rd(5'h0C, d); chk("R11 flag survives rst_n", d[9] == 1'b1, d[9], 1);
        wr(5'h0C, 32'h200);
        rd(5'h0C, d); chk("R11 unkeyed clear ignored", d[9] == 1'b1, d[9], 1);
        unl(); wr(5'h0C, 32'h200);
        rd(5'h0C, d); chk("R11 keyed clear", d[9] == 1'b0, d[9], 0);

        // R9 status clear
        sysreset();
        unl(); wr(5'h00, 32'h1); unl(); wr(5'h04, 32'h8);
        wr(5'h10, 32'h4); wr(5'h14, 32'h2);
        wait_irq(n);
        chk("R9 irq raised", irq_o == 1'b1, irq_o, 1);
        wr(5'h08, 32'h1);
        chk("R9 irq cleared", irq_o == 1'b0, irq_o, 0);
        rd(5'h08, d); chk("R9 status cleared", d == 0, d, 0);

        // R9 masked interrupt type
        sysreset();
        unl(); wr(5'h00, 32'h1); unl(); wr(5'h04, 32'h2);
        wr(5'h10, 32'h7);
        saw_irq = 0; mon_en = 1;
        wr(5'h14, 32'h2);
        wait_rst(n);
        mon_en = 0;
        chk("R9 masked no irq", !saw_irq, saw_irq, 0);
        chk("R9 reset still fires", wdt_rst_o == 1'b1, wdt_rst_o, 1);

        // R10 reset output suppressed, flag still set
        sysreset();
        unl(); wr(5'h0C, 32'h200);
        unl(); wr(5'h00, 32'h1); unl(); wr(5'h04, 32'h1);
        wr(5'h10, 32'h24);
        saw_rst = 0; mon_en = 1;
        wr(5'h14, 32'h2);
        idle(60);
        mon_en = 0;
        chk("R10 no reset output", !saw_rst, saw_rst, 0);
        rd(5'h0C, d); chk("R10 flag set", d[9] == 1'b1, d[9], 1);

        // R13 timer mode
        sysreset();
        unl(); wr(5'h0C, 32'h200);
        unl(); wr(5'h00, 32'h1); unl(); wr(5'h04, 32'h1);
        wr(5'h10, 32'h4);
        saw_rst = 0; mon_en = 1;
        wr(5'h14, 32'h6);
        idle(80);
        mon_en = 0;
        chk("R13 no reset in timer mode", !saw_rst, saw_rst, 0);
        chk("R13 irq in timer mode", irq_o == 1'b1, irq_o, 1);
        rd(5'h0C, d); chk("R13 flag untouched", d[9] == 1'b0, d[9], 0);

        // R12 keepalive
        sysreset();
        unl(); wr(5'h00, 32'h3); unl(); wr(5'h04, 32'h3);
        wr(5'h10, 32'h4);
        saw_irq = 0; mon_en = 1;
        wr(5'h14, 32'h2);
        for (int k = 0; k < 12; k++) begin
            idle(2);
            unl(); wr(5'h0C, 32'h100);
        end
        mon_en = 0;
        chk("R12 kicks hold off irq", !saw_irq, saw_irq, 0);
        wait_irq(n);
        chk("R12 irq after kicks stop", n >= 9 && n <= 12, n, 12);

        // R6 disable
        sysreset();
        unl(); wr(5'h00, 32'h2); unl(); wr(5'h04, 32'h2);
        wr(5'h10, 32'h4);
        wr(5'h14, 32'h2);
        idle(2);
        saw_irq = 0; saw_rst = 0; mon_en = 1;
        wr(5'h14, 32'h0);
        idle(100);
        mon_en = 0;
        chk("R6 no irq after disable", !saw_irq, saw_irq, 0);
        chk("R6 no reset after disable", !saw_rst, saw_rst, 0);
        rd(5'h14, d); chk("R6 enable reads 0", d == 0, d, 0);

        // R5 lock
        sysreset();
        wr(5'h14, 32'h3);
        wr(5'h14, 32'h0);
        rd(5'h14, d); chk("R5 locked write ignored", d == 3, d, 3);
        sysreset();
        rd(5'h14, d); chk("R5 lock cleared by rst_n", d == 0, d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule